// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight interrupt request lines and raises one interrupt output toward a processor. After an acknowledge it returns an 8-bit vector that names the winning line. Software sets it up with a short run of initialization bytes, then steers it with operation bytes on a command port and a data port. The data port also carries an 8-bit mask. A read of either port returns a selected internal register.

A stored lowest-priority pointer decides which line wins. The priority scan starts just above that pointer and wraps around, and a line already in service holds off every line below it. End-of-interrupt commands can rotate the pointer, and automatic end-of-interrupt can do the same. Special mask mode lets masked in-service lines stop blocking. Special fully-nested mode lets the cascade line (pin 2) interrupt itself again. A poll read returns the winner directly without the acknowledge cycle.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset, or after any command byte with bit 4 set (first initialization byte), the following hold: the request and mask registers are zero, the lowest-priority pointer is 7, command reads select the request register, poll and special mask mode are off, the interrupt output is low, and the controller is not ready.
- R2: The initialization bytes after the first arrive on the data port. The first data byte sets the vector base to its bits 7:3. A third byte is expected only when bit 1 of the first byte is 0. A fourth byte is expected only when bit 0 of the first byte is 1. The controller becomes ready after the last expected byte. An acknowledged vector is {base, pin[2:0]}.
- R3: While the controller is not ready, request lines set no request bits. An edge seen during that time does not become pending later.
- R4: When the controller is ready, a data-port write loads the mask register. A data-port read returns the mask register. A masked line never wins.
- R5: The scan visits pins lowprio+1, lowprio+2, ... modulo 8. The first pin whose request bit is set and whose mask bit is clear wins. If the scan reaches an in-service pin first, there is no winner.
- R6: On an edge-triggered pin, a rising edge sets the request bit and acknowledge clears it. On a pin with irq_lvl set, the request bit follows the line: acknowledge leaves it set while the line is high, and it clears when the line goes low.
- R7: The interrupt output rises only when ready and a winner exists. It stays high until acknowledge and is low in the cycle after acknowledge. The acknowledge vector uses pin 7 when no winner exists.
- R8: In a command byte with bits 4:3 = 00, bit 7 is the rotate bit, bit 6 is the select-level bit and bit 5 is the EOI bit. EOI=1 with select-level=0 clears the in-service bit that comes first in the scan order. If the rotate bit is also 1, the cleared pin becomes the lowest-priority pin.
- R9: In that same command byte, rotate=1, select-level=1 and EOI=0 load the lowest-priority pointer from bits 2:0.
- R10: Bit 1 of the fourth initialization byte selects automatic end-of-interrupt. In that mode an acknowledge sets no in-service bit. If the stored rotate bit (from the last byte of R8 form) is 1, the acknowledged pin becomes the lowest-priority pin.
- R11: In a command byte with bits 4:3 = 01, bit 6=1 writes bit 5 into special mask mode. While that mode is on, in-service bits whose mask bit is set do not block, and a non-specific EOI skips them.
- R12: Bit 4 of the fourth initialization byte selects special fully-nested mode. In that mode the in-service bit of pin 2 does not block a new request on pin 2.
- R13: In a command byte with bits 4:3 = 01, bit 1=1 selects the command-read source from bit 0: 1 selects the in-service register and 0 selects the request register. Read data appears on rdata in the cycle after the read strobe.
- R14: In that same command byte, bit 2=1 arms poll. The next command read returns 0x80|pin if a winner exists and 0x00 if not, then disarms. A winner found by the poll is accepted as if acknowledged, which also drops the interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command-port write strobe |
| dat_wr | input | 1 | Data-port write strobe |
| wdata | input | 8 | Write data for either port |
| cmd_rd | input | 1 | Command-port read strobe |
| dat_rd | input | 1 | Data-port read strobe |
| rdata | output | 8 | Registered read data |
| irq_line | input | 8 | Interrupt request lines |
| irq_lvl | input | 8 | Per-pin level-sensitive select (1 = level) |
| int_req | output | 1 | Interrupt output to the processor |
| int_ack | input | 1 | One-cycle acknowledge pulse |
| ack_vector | output | 8 | Vector captured on acknowledge |

## Verification
The assertions assume that request lines, strobes and acknowledge are synchronous to clk. They also assume that at most one of cmd_wr, dat_wr, cmd_rd and int_ack is high in a cycle, and that int_ack is a single-cycle pulse. The poll-disarm property further assumes that no command write shares the cycle with a poll read. The bench changes every input on the falling edge, issues one strobe per task step, and never overlaps a read with a write, so it stays inside these conditions.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  localparam int NPIN        = 8;
  localparam int PW          = $clog2(NPIN);
  localparam int DW          = 8;
  localparam int CASCADE_PIN = 2;
  localparam int BASE_W      = DW - PW;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_W2   = 2'd1,
    SEQ_W3   = 2'd2,
    SEQ_W4   = 2'd3
  } seq_e;
endpackage

// File: rtl/pic8_scan.sv
// Circular first-hit finder: walks from start+1 around to start.
// A set block bit ends the walk with no hit.
module pic8_scan #(
  parameter int NPIN = 8,
  parameter int PW   = $clog2(NPIN)
) (
  input  logic [NPIN-1:0] bits_i,
  input  logic [NPIN-1:0] block_i,
  input  logic [PW-1:0]   start_i,
  output logic            hit_o,
  output logic [PW-1:0]   pin_o
);
  always_comb begin
    logic done;
    done  = 1'b0;
    hit_o = 1'b0;
    pin_o = '0;
    for (int k = 1; k <= NPIN; k++) begin : walk
      logic [PW-1:0] idx;
      idx = start_i + PW'(k);
      if (!done) begin
        if (block_i[idx]) begin
          done = 1'b1;
        end else if (bits_i[idx]) begin
          hit_o = 1'b1;
          pin_o = idx;
          done  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pic8_req.sv
// Request register: edge or level capture per pin, cleared on acceptance.
module pic8_req #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ready_i,
  input  logic            clr_all_i,
  input  logic [NPIN-1:0] line_i,
  input  logic [NPIN-1:0] lvl_i,
  input  logic [NPIN-1:0] accept_i,
  output logic [NPIN-1:0] req_o
);
  logic [NPIN-1:0] line_q;
  logic [NPIN-1:0] req_q;

  always_ff @(posedge clk) begin
    if (rst) line_q <= '0;
    else     line_q <= line_i;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_bit
    logic set_b;
    logic drop_b;
    assign set_b  = ready_i && (lvl_i[i] ? line_i[i] : (line_i[i] && !line_q[i]));
    assign drop_b = (lvl_i[i] && !line_i[i]) || accept_i[i];

    always_ff @(posedge clk) begin
      if (rst || clr_all_i) req_q[i] <= 1'b0;
      else if (set_b)       req_q[i] <= 1'b1;
      else if (drop_b)      req_q[i] <= 1'b0;
    end
  end

  assign req_o = req_q;

  assert_notready_R3: assert property (@(posedge clk) disable iff (rst)
    !ready_i |=> ((req_q & ~$past(req_q)) == '0));
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
  import pic8_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr,
  input  logic          dat_wr,
  input  logic [DW-1:0] wdata,
  input  logic          cmd_rd,
  input  logic          dat_rd,
  output logic [DW-1:0] rdata,
  input  logic [NPIN-1:0] irq_line,
  input  logic [NPIN-1:0] irq_lvl,
  output logic          int_req,
  input  logic          int_ack,
  output logic [DW-1:0] ack_vector
);
  localparam logic [PW-1:0] LOW_RESET = PW'(NPIN - 1);

  seq_e              seq;
  logic              need_w3, need_w4, ready;
  logic [BASE_W-1:0] base;
  logic [NPIN-1:0]   mask, isr, req;
  logic [PW-1:0]     lowprio;
  logic              rotate, aeoi, sfn, smm, rd_isr, poll;

  // command decode
  logic is_icw1, is_ocw2, is_ocw3, ns_eoi, set_pri, poll_take, accept;
  assign is_icw1   = cmd_wr && wdata[4];
  assign is_ocw2   = cmd_wr && ready && !wdata[4] && !wdata[3];
  assign is_ocw3   = cmd_wr && ready && !wdata[4] &&  wdata[3];
  assign ns_eoi    = is_ocw2 &&  wdata[5] && !wdata[6];
  assign set_pri   = is_ocw2 && !wdata[5] &&  wdata[6] && wdata[7];
  assign poll_take = cmd_rd && poll;

  // priority resolution
  logic [NPIN-1:0] isr_eff, smm_hide, sfn_hide;
  logic            win_hit, eoi_hit;
  logic [PW-1:0]   win_pin, eoi_pin;

  assign smm_hide = smm ? mask : '0;
  assign sfn_hide = sfn ? (NPIN'(1) << CASCADE_PIN) : '0;
  assign isr_eff  = isr & ~smm_hide & ~sfn_hide;

  pic8_scan #(.NPIN(NPIN), .PW(PW)) u_win (
    .bits_i (req & ~mask),
    .block_i(isr_eff),
    .start_i(lowprio),
    .hit_o  (win_hit),
    .pin_o  (win_pin)
  );

  pic8_scan #(.NPIN(NPIN), .PW(PW)) u_eoi (
    .bits_i (isr & ~smm_hide),
    .block_i('0),
    .start_i(lowprio),
    .hit_o  (eoi_hit),
    .pin_o  (eoi_pin)
  );

  assign accept = (int_ack || poll_take) && win_hit;

  logic [NPIN-1:0] accept_oh, eoi_oh;
  assign accept_oh = accept ? (NPIN'(1) << win_pin) : '0;
  assign eoi_oh    = (ns_eoi && eoi_hit) ? (NPIN'(1) << eoi_pin) : '0;

  pic8_req #(.NPIN(NPIN)) u_req (
    .clk      (clk),
    .rst      (rst),
    .ready_i  (ready),
    .clr_all_i(is_icw1),
    .line_i   (irq_line),
    .lvl_i    (irq_lvl),
    .accept_i (accept_oh),
    .req_o    (req)
  );

  // initialization sequence and mode registers
  always_ff @(posedge clk) begin
    if (rst) begin
      seq <= SEQ_IDLE; need_w3 <= 1'b0; need_w4 <= 1'b0; ready <= 1'b0;
      base <= '0; mask <= '0; aeoi <= 1'b0; sfn <= 1'b0;
      smm <= 1'b0; rd_isr <= 1'b0; poll <= 1'b0; rotate <= 1'b0;
    end else if (is_icw1) begin
      seq <= SEQ_W2; need_w3 <= !wdata[1]; need_w4 <= wdata[0]; ready <= 1'b0;
      mask <= '0; aeoi <= 1'b0; sfn <= 1'b0;
      smm <= 1'b0; rd_isr <= 1'b0; poll <= 1'b0; rotate <= 1'b0;
    end else begin
      if (dat_wr) begin
        unique case (seq)
          SEQ_W2: begin
            base <= wdata[DW-1:PW];
            if (need_w3)      seq <= SEQ_W3;
            else if (need_w4) seq <= SEQ_W4;
            else begin seq <= SEQ_IDLE; ready <= 1'b1; end
          end
          SEQ_W3: begin
            if (need_w4) seq <= SEQ_W4;
            else begin seq <= SEQ_IDLE; ready <= 1'b1; end
          end
          SEQ_W4: begin
            aeoi <= wdata[1];
            sfn  <= wdata[4];
            seq  <= SEQ_IDLE;
            ready <= 1'b1;
          end
          default: mask <= wdata;
        endcase
      end
      if (is_ocw2) rotate <= wdata[7];
      if (is_ocw3) begin
        if (wdata[1]) rd_isr <= wdata[0];
        if (wdata[6]) smm    <= wdata[5];
        poll <= wdata[2];
      end else if (poll_take) begin
        poll <= 1'b0;
      end
    end
  end

  // in-service register and priority pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      isr     <= '0;
      lowprio <= LOW_RESET;
    end else begin
      isr <= (isr & ~eoi_oh) | (aeoi ? '0 : accept_oh);
      if (is_icw1)                         lowprio <= LOW_RESET;
      else if (set_pri)                    lowprio <= wdata[PW-1:0];
      else if (ns_eoi && eoi_hit && wdata[7]) lowprio <= eoi_pin;
      else if (accept && aeoi && rotate)   lowprio <= win_pin;
    end
  end

  // interrupt output, vector and read-back
  always_ff @(posedge clk) begin
    if (rst) begin
      int_req    <= 1'b0;
      ack_vector <= '0;
      rdata      <= '0;
    end else begin
      if (is_icw1 || int_ack || poll_take)   int_req <= 1'b0;
      else if (ready && win_hit && !int_req) int_req <= 1'b1;

      if (int_ack) ack_vector <= {base, win_hit ? win_pin : LOW_RESET};

      if (cmd_rd) begin
        if (poll)        rdata <= win_hit ? {1'b1, {(DW-1-PW){1'b0}}, win_pin} : '0;
        else if (rd_isr) rdata <= isr;
        else             rdata <= req;
      end else if (dat_rd) begin
        rdata <= mask;
      end
    end
  end

  assert_init_clears_R1: assert property (@(posedge clk) disable iff (rst)
    is_icw1 |=> (mask == '0 && req == '0 && lowprio == LOW_RESET && !ready && !int_req && !poll && !smm));

  assert_win_legal_R5: assert property (@(posedge clk) disable iff (rst)
    win_hit |-> (req[win_pin] && !mask[win_pin]));

  assert_rise_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(int_req) |-> $past(ready && win_hit));

  assert_ack_drops_R7: assert property (@(posedge clk) disable iff (rst)
    int_ack |=> !int_req);

  assert_auto_eoi_R10: assert property (@(posedge clk) disable iff (rst)
    (aeoi && !cmd_wr) |=> ((isr & ~$past(isr)) == '0));

  assert_poll_once_R14: assert property (@(posedge clk) disable iff (rst)
    (poll_take && !cmd_wr) |=> !poll);
endmodule

// File: tb/pic8_ctrl_bench.sv
module pic8_ctrl_bench;
  localparam time TCLK = 10ns;

  logic       clk = 1'b0;
  logic       rst;
  logic       cmd_wr = 0, dat_wr = 0, cmd_rd = 0, dat_rd = 0, int_ack = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata, ack_vector;
  logic [7:0] irq_line = 0, irq_lvl = 0;
  logic       int_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(TCLK/2) clk = ~clk;

  pic8_ctrl u_pic8_ctrl (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .dat_wr(dat_wr), .wdata(wdata),
    .cmd_rd(cmd_rd), .dat_rd(dat_rd), .rdata(rdata), .irq_line(irq_line),
    .irq_lvl(irq_lvl), .int_req(int_req), .int_ack(int_ack), .ack_vector(ack_vector)
  );

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd_w(logic [7:0] b);
    wdata = b; cmd_wr = 1; @(negedge clk); cmd_wr = 0;
  endtask

  task automatic dat_w(logic [7:0] b);
    wdata = b; dat_wr = 1; @(negedge clk); dat_wr = 0;
  endtask

  task automatic cmd_r(output logic [7:0] v);
    cmd_rd = 1; @(negedge clk); cmd_rd = 0; v = rdata;
  endtask

  task automatic dat_r(output logic [7:0] v);
    dat_rd = 1; @(negedge clk); dat_rd = 0; v = rdata;
  endtask

  task automatic ack(string req, logic [7:0] exp);
    int_ack = 1; @(negedge clk); int_ack = 0;
    check8(req, ack_vector, exp);
    check8("R7 output low after acknowledge", {7'd0, int_req}, 8'h00);
  endtask

  task automatic raise(logic [7:0] bits);
    irq_line = irq_line | bits; wait_n(3);
  endtask

  task automatic lower(logic [7:0] bits);
    irq_line = irq_line & ~bits; wait_n(2);
  endtask

  task automatic init(logic [7:0] w4);
    cmd_w(8'h13); dat_w(8'h20); dat_w(w4);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check8("R1 int_req after reset", {7'd0, int_req}, 8'h00);
    dat_r(v); check8("R1 mask after reset", v, 8'h00);
    cmd_r(v); check8("R1 request readback after reset", v, 8'h00);
  endtask

  task automatic t_mask_rw;
    logic [7:0] v;
    init(8'h01);
    dat_w(8'hA5); dat_r(v); check8("R4 mask readback", v, 8'hA5);
    dat_w(8'h00);
  endtask

  task automatic t_basic;
    logic [7:0] v;
    raise(8'h08);
    check8("R7 output raised", {7'd0, int_req}, 8'h01);
    cmd_r(v); check8("R13 request register", v, 8'h08);
    ack("R2 vector base plus pin 3", 8'h23);
    cmd_w(8'h0B); cmd_r(v); check8("R13 in-service register", v, 8'h08);
    cmd_w(8'h0A); cmd_r(v); check8("R6 edge request cleared by acknowledge", v, 8'h00);
    lower(8'h08);
    cmd_w(8'h20); cmd_w(8'h0B); cmd_r(v); check8("R8 non-specific EOI clears", v, 8'h00);
    cmd_w(8'h0A);
  endtask

  task automatic t_priority;
    raise(8'h22);
    ack("R5 lower pin wins with pointer 7", 8'h21);
    wait_n(3);
    check8("R5 in-service pin blocks lower priority", {7'd0, int_req}, 8'h00);
    cmd_w(8'h20); wait_n(3);
    check8("R7 output raised after EOI", {7'd0, int_req}, 8'h01);
    ack("R5 next pin", 8'h25);
    cmd_w(8'h20); lower(8'h22);
  endtask

  task automatic t_mask_block;
    logic [7:0] v;
    dat_w(8'h10); raise(8'h10);
    check8("R4 masked pin does not raise output", {7'd0, int_req}, 8'h00);
    cmd_r(v); check8("R4 masked request still recorded", v, 8'h10);
    dat_w(8'h00); wait_n(3);
    check8("R4 unmasked pin raises output", {7'd0, int_req}, 8'h01);
    ack("R4 vector after unmask", 8'h24);
    cmd_w(8'h20); lower(8'h10);
  endtask

  task automatic t_rotate;
    raise(8'h04); ack("R8 pin 2 vector", 8'h22);
    cmd_w(8'hA0); lower(8'h04);
    raise(8'h12);
    ack("R8 rotated pointer favours pin 4", 8'h24);
    wait_n(3);
    check8("R8 pin 1 blocked by pin 4 in service", {7'd0, int_req}, 8'h00);
    cmd_w(8'hA0); wait_n(3);
    ack("R8 pin 1 after rotating EOI", 8'h21);
    cmd_w(8'h20); lower(8'h12);
  endtask

  task automatic t_setpri;
    cmd_w(8'hC5);
    raise(8'h41);
    ack("R9 pointer 5 favours pin 6", 8'h26);
    cmd_w(8'h20); wait_n(3);
    ack("R9 pin 0 next", 8'h20);
    cmd_w(8'h20); cmd_w(8'hC7); lower(8'h41);
  endtask

  task automatic t_aeoi;
    logic [7:0] v;
    init(8'h03);
    cmd_w(8'h80);
    raise(8'h08); ack("R10 auto-EOI vector", 8'h23);
    cmd_w(8'h0B); cmd_r(v); check8("R10 no in-service bit", v, 8'h00);
    lower(8'h08);
    raise(8'h22);
    ack("R10 rotation to pin 3 favours pin 5", 8'h25);
    wait_n(3);
    ack("R10 pin 1 follows", 8'h21);
    cmd_w(8'h00); lower(8'h22);
  endtask

  task automatic t_smm;
    logic [7:0] v;
    init(8'h01);
    raise(8'h04); ack("R11 pin 2 vector", 8'h22);
    raise(8'h40);
    check8("R11 pin 6 blocked by pin 2", {7'd0, int_req}, 8'h00);
    dat_w(8'h04); wait_n(3);
    check8("R11 still blocked without special mask", {7'd0, int_req}, 8'h00);
    cmd_w(8'h68); wait_n(3);
    check8("R11 masked in-service no longer blocks", {7'd0, int_req}, 8'h01);
    ack("R11 pin 6 vector", 8'h26);
    cmd_w(8'h20);
    cmd_w(8'h0B); cmd_r(v); check8("R11 EOI skipped masked pin 2", v, 8'h04);
    cmd_w(8'h48); dat_w(8'h00); cmd_w(8'h20);
    cmd_r(v); check8("R11 pin 2 cleared after mode off", v, 8'h00);
    lower(8'h44);
  endtask

  task automatic t_sfn;
    logic [7:0] v;
    init(8'h11);
    raise(8'h04); ack("R12 first pin 2 vector", 8'h22);
    lower(8'h04); raise(8'h04);
    check8("R12 pin 2 re-raises while in service", {7'd0, int_req}, 8'h01);
    ack("R12 second pin 2 vector", 8'h22);
    cmd_w(8'h0B); cmd_r(v); check8("R12 in-service pin 2", v, 8'h04);
    cmd_w(8'h20); lower(8'h04);
  endtask

  task automatic t_poll;
    logic [7:0] v;
    init(8'h01);
    raise(8'h20);
    cmd_w(8'h0C); cmd_r(v);
    check8("R14 poll result", v, 8'h85);
    check8("R14 poll drops output", {7'd0, int_req}, 8'h00);
    cmd_w(8'h0B); cmd_r(v); check8("R14 poll marks in service", v, 8'h20);
    cmd_w(8'h20); lower(8'h20);
    cmd_w(8'h0C); cmd_r(v); check8("R14 empty poll", v, 8'h00);
    cmd_r(v); check8("R14 poll disarmed", v, 8'h00);
  endtask

  task automatic t_notready;
    logic [7:0] v;
    cmd_w(8'h13);
    raise(8'h01);
    dat_w(8'h20); dat_w(8'h01); wait_n(3);
    check8("R3 no output from edge while not ready", {7'd0, int_req}, 8'h00);
    cmd_r(v); check8("R3 request not captured", v, 8'h00);
    lower(8'h01);
  endtask

  task automatic t_level;
    logic [7:0] v;
    irq_lvl = 8'h80;
    raise(8'h80);
    ack("R6 level pin 7 vector", 8'h27);
    cmd_r(v); check8("R6 level request kept while high", v, 8'h80);
    lower(8'h80);
    cmd_r(v); check8("R6 level request clears when low", v, 8'h00);
    cmd_w(8'h20); irq_lvl = 8'h00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1;
    wait_n(3);
    rst = 0;
    wait_n(1);
    t_reset;
    t_mask_rw;
    t_basic;
    t_priority;
    t_mask_block;
    t_rotate;
    t_setpri;
    t_aeoi;
    t_smm;
    t_sfn;
    t_poll;
    t_notready;
    t_level;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule